// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block keeps the base mode register of a DDR-style memory controller or memory model, and it turns each access command into a run of column addresses, one per beat. A mode-register-set command carries a two-bit bank-select value and an address word. When the bank select is zero, the block decodes the address word into four fields: burst length, burst order, read latency and operating mode. Reserved codes are refused. The field keeps its earlier value and a sticky error flag rises.

When a READ or WRITE command is accepted, the block latches the starting column and then presents one column address per clock. Every address stays inside an aligned block whose size is the burst length, and it wraps at the block edge. Beats follow either a sequential (modulo add) order or an interleaved (XOR) order. The last beat is marked. A further command is taken in that last-beat cycle without a gap, or at once when the truncation input is high. For reads, a one-cycle marker shows when the first read data is due, and the latency is reported as an integer cycle count plus a half-cycle flag.

Top module: `burst_col_seq`

## Requirements
- R1: While rstN is low (asynchronous, active low) and after it is released, colValid, colLast, rdDue, dllResetReq and modeErr are 0. The mode defaults to a burst length of 4, sequential order and a latency of 2 (casCycles=2, casHalf=0).
- R2: A mode write to bank 0 takes the burst length from mrsAddr[2:0]: code 001 gives 2 beats, 010 gives 4 beats and 011 gives 8 beats.
- R3: mrsAddr[3]=0 selects sequential order, where the low offset of beat k is (start+k) mod L. mrsAddr[3]=1 selects interleaved order, where the low offset is start XOR k. Here start is cmdCol mod L.
- R4: Every beat keeps the column bits at and above log2(L) equal to those of cmdCol. The burst therefore wraps inside its aligned block.
- R5: colValid rises in the cycle after a command is accepted, with beatIdx=0. beatIdx then rises by one each cycle with no gap. colLast is high only on beat L-1.
- R6: READ and WRITE commands use the same length and order. colIsRead equals cmdIsRead of the command that owns the beat.
- R7: mrsAddr[6:4]=010 gives casCycles=2 and casHalf=0. mrsAddr[6:4]=110 gives casCycles=2 and casHalf=1. For a READ accepted at clock edge n, rdDue is high for exactly the one cycle that follows edge n+2. WRITE commands raise no rdDue.
- R8: A mode write whose mrsBank is not 0 changes no field. It raises no modeErr and produces no dllResetReq.
- R9: A reserved code in the length field, in the latency field, or in the operating-mode field mrsAddr[ADDR_W-1:7] sets modeErr, and modeErr stays set until reset. The reserved field keeps its previous value, and the valid fields of the same write still take effect.
- R10: An operating-mode field of all zeros means normal operation. A field in which only mrsAddr[8] is set produces a one-cycle dllResetReq pulse in the cycle after the write edge.
- R11: A command is accepted when the block is idle, or in a cycle where colLast is 1; in that case the new beat 0 follows without a gap. While a burst is running, a command without truncate waits. A command with truncate=1 is accepted at once, drops the rest of the running burst, and starts beat 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mrsValid | input | 1 | Mode-register-set command strobe |
| mrsBank | input | BA_W | Bank select of the mode write |
| mrsAddr | input | ADDR_W | Address word carrying the mode fields |
| cmdValid | input | 1 | Access command request |
| cmdIsRead | input | 1 | 1 for READ, 0 for WRITE |
| cmdCol | input | COL_W | Starting column of the access |
| truncate | input | 1 | Abandon the running burst for the new command |
| colValid | output | 1 | A beat address is presented |
| colAddr | output | COL_W | Column address of the current beat |
| beatIdx | output | 3 | Index of the current beat |
| colLast | output | 1 | Current beat is the final one |
| colIsRead | output | 1 | Current burst is a READ |
| rdDue | output | 1 | First read data due at this point |
| casCycles | output | 2 | Integer part of the read latency |
| casHalf | output | 1 | Read latency carries an extra half cycle |
| dllResetReq | output | 1 | One-cycle DLL reset request |
| modeErr | output | 1 | Sticky flag for reserved mode codes |

## Verification
A command accepted at edge n shows beat 0 after that same edge, and each later beat follows one edge after the one before it. A mode write at edge n is visible in the mode outputs and in dllResetReq right after edge n. rdDue for a READ accepted at edge n appears after edge n+2. The bench drives inputs one time step after a falling edge and samples at every falling edge. Each expected beat is queued when its command is driven, and each read's due cycle is recorded as the command-driving cycle plus three. Every comparison therefore lands in the exact cycle in which the result must appear.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int BEAT_W  = 3;
  localparam int CAS_W   = 2;
  localparam int MAX_CAS = 3;
  localparam int OP_LSB  = 7;

  typedef struct packed {
    logic load;
    logic advance;
  } seq_strobe_t;
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
  import bcs_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mrsValid,
  input  logic [BA_W-1:0]   mrsBank,
  input  logic [ADDR_W-1:0] mrsAddr,
  output logic [BEAT_W-1:0] lenMask,
  output logic              ilvMode,
  output logic [CAS_W-1:0]  casCycles,
  output logic              casHalf,
  output logic              dllResetReq,
  output logic              modeErr
);
  localparam int OP_W = ADDR_W - OP_LSB;

  logic              writeHit;
  logic [2:0]        lenCode;
  logic [2:0]        casCode;
  logic [OP_W-1:0]   opField;
  logic              lenOk, casOk, opNormal, opDll, opOk;
  logic [BEAT_W-1:0] lenMaskNew;

  assign writeHit = mrsValid && (mrsBank == '0);
  assign lenCode  = mrsAddr[2:0];
  assign casCode  = mrsAddr[6:4];
  assign opField  = mrsAddr[ADDR_W-1:OP_LSB];
  assign opNormal = (opField == '0);
  assign opDll    = (opField == OP_W'(2));
  assign opOk     = opNormal || opDll;
  assign casOk    = (casCode == 3'b010) || (casCode == 3'b110);

  always_comb begin
    lenOk      = 1'b1;
    lenMaskNew = lenMask;
    unique case (lenCode)
      3'b001:  lenMaskNew = 3'd1;
      3'b010:  lenMaskNew = 3'd3;
      3'b011:  lenMaskNew = 3'd7;
      default: lenOk      = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenMask     <= 3'd3;
      ilvMode     <= 1'b0;
      casCycles   <= CAS_W'(2);
      casHalf     <= 1'b0;
      dllResetReq <= 1'b0;
      modeErr     <= 1'b0;
    end else begin
      dllResetReq <= writeHit && opDll;
      if (writeHit) begin
        ilvMode <= mrsAddr[3];
        if (lenOk) lenMask <= lenMaskNew;
        if (casOk) begin
          casCycles <= CAS_W'(2);
          casHalf   <= casCode[2];
        end
        if (!(lenOk && casOk && opOk)) modeErr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdIsRead,
  input  logic             truncate,
  input  logic             atEnd,
  input  logic [CAS_W-1:0] casCycles,
  output seq_strobe_t      strobe,
  output logic             cmdTake,
  output logic             busy,
  output logic             lastBeat,
  output logic             rdDue
);
  logic [MAX_CAS:0] rdPipe;

  assign lastBeat = busy && atEnd;
  assign cmdTake  = cmdValid && (!busy || lastBeat || truncate);

  always_comb begin
    strobe.load    = cmdTake;
    strobe.advance = busy && !atEnd && !cmdTake;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
    end else if (cmdTake) begin
      busy <= 1'b1;
    end else if (lastBeat) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdPipe[0] <= 1'b0;
    else       rdPipe[0] <= cmdTake && cmdIsRead;
  end

  for (genvar s = 1; s <= MAX_CAS; s++) begin : g_rd_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rdPipe[s] <= 1'b0;
      else       rdPipe[s] <= rdPipe[s-1];
    end
  end

  assign rdDue = rdPipe[casCycles];
endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobe,
  input  logic [COL_W-1:0]  cmdCol,
  input  logic              cmdIsRead,
  input  logic [BEAT_W-1:0] lenMask,
  input  logic              ilvMode,
  output logic [COL_W-1:0]  colAddr,
  output logic [BEAT_W-1:0] beatIdx,
  output logic              atEnd,
  output logic              colIsRead
);
  logic [COL_W-1:0]  startCol;
  logic [BEAT_W-1:0] burstMask;
  logic              burstIlv;
  logic [BEAT_W-1:0] startLow, seqOff, ilvOff, offset;
  logic [COL_W-1:0]  maskWide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startCol  <= '0;
      burstMask <= '0;
      burstIlv  <= 1'b0;
      colIsRead <= 1'b0;
      beatIdx   <= '0;
    end else if (strobe.load) begin
      startCol  <= cmdCol;
      burstMask <= lenMask;
      burstIlv  <= ilvMode;
      colIsRead <= cmdIsRead;
      beatIdx   <= '0;
    end else if (strobe.advance) begin
      beatIdx   <= beatIdx + 1'b1;
    end
  end

  assign startLow = startCol[BEAT_W-1:0];
  assign seqOff   = startLow + beatIdx;
  assign ilvOff   = startLow ^ beatIdx;
  assign offset   = burstIlv ? ilvOff : seqOff;
  assign maskWide = {{(COL_W-BEAT_W){1'b0}}, burstMask};
  assign colAddr  = (startCol & ~maskWide) |
                    ({{(COL_W-BEAT_W){1'b0}}, offset} & maskWide);
  assign atEnd    = (beatIdx == burstMask);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int BA_W   = 2,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mrsValid,
  input  logic [BA_W-1:0]   mrsBank,
  input  logic [ADDR_W-1:0] mrsAddr,
  input  logic              cmdValid,
  input  logic              cmdIsRead,
  input  logic [COL_W-1:0]  cmdCol,
  input  logic              truncate,
  output logic              colValid,
  output logic [COL_W-1:0]  colAddr,
  output logic [2:0]        beatIdx,
  output logic              colLast,
  output logic              colIsRead,
  output logic              rdDue,
  output logic [1:0]        casCycles,
  output logic              casHalf,
  output logic              dllResetReq,
  output logic              modeErr
);
  seq_strobe_t       strobe;
  logic [BEAT_W-1:0] lenMask;
  logic              ilvMode;
  logic              atEnd;
  logic              cmdTake;

  bcs_mode_reg #(.BA_W(BA_W), .ADDR_W(ADDR_W)) u_mode (
    .clk(clk), .rstN(rstN), .mrsValid(mrsValid), .mrsBank(mrsBank),
    .mrsAddr(mrsAddr), .lenMask(lenMask), .ilvMode(ilvMode),
    .casCycles(casCycles), .casHalf(casHalf),
    .dllResetReq(dllResetReq), .modeErr(modeErr)
  );

  bcs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIsRead(cmdIsRead),
    .truncate(truncate), .atEnd(atEnd), .casCycles(casCycles),
    .strobe(strobe), .cmdTake(cmdTake), .busy(colValid),
    .lastBeat(colLast), .rdDue(rdDue)
  );

  bcs_datapath #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdCol(cmdCol),
    .cmdIsRead(cmdIsRead), .lenMask(lenMask), .ilvMode(ilvMode),
    .colAddr(colAddr), .beatIdx(beatIdx), .atEnd(atEnd),
    .colIsRead(colIsRead)
  );
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int COL_W = 10,
  parameter int BA_W  = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             mrsValid,
  input logic [BA_W-1:0]  mrsBank,
  input logic             cmdValid,
  input logic             cmdIsRead,
  input logic             truncate,
  input logic             cmdTake,
  input logic             colValid,
  input logic [COL_W-1:0] colAddr,
  input logic [2:0]       beatIdx,
  input logic             colLast,
  input logic             colIsRead,
  input logic             rdDue,
  input logic [1:0]       casCycles,
  input logic             casHalf,
  input logic             dllResetReq,
  input logic             modeErr
);
  logic midBurst;
  assign midBurst = colValid && !colLast && !(cmdValid && truncate);

  a_r5_beat_step: assert property (@(posedge clk) disable iff (!rstN)
    midBurst |=> colValid && (beatIdx == $past(beatIdx) + 3'd1));

  a_r5_last_in_burst: assert property (@(posedge clk) disable iff (!rstN)
    colLast |-> colValid);

  a_r4_block_fixed: assert property (@(posedge clk) disable iff (!rstN)
    midBurst |=> (colAddr >> 3) == ($past(colAddr) >> 3));

  a_r6_dir_stable: assert property (@(posedge clk) disable iff (!rstN)
    midBurst |=> $stable(colIsRead));

  a_r11_first_beat: assert property (@(posedge clk) disable iff (!rstN)
    cmdTake |=> colValid && (beatIdx == 3'd0) && (colIsRead == $past(cmdIsRead)));

  a_r7_read_due: assert property (@(posedge clk) disable iff (!rstN)
    (cmdTake && cmdIsRead && casCycles == 2'd2) |=> ##2 rdDue);

  a_r8_bank_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (mrsValid && mrsBank != '0) |=> $stable(casHalf) && $stable(modeErr) && !dllResetReq);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |=> modeErr);

  a_r10_dll_from_write: assert property (@(posedge clk) disable iff (!rstN)
    dllResetReq |-> $past(mrsValid));
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W), .BA_W(BA_W)) u_chk (
  .clk(clk), .rstN(rstN), .mrsValid(mrsValid), .mrsBank(mrsBank),
  .cmdValid(cmdValid), .cmdIsRead(cmdIsRead), .truncate(truncate),
  .cmdTake(cmdTake), .colValid(colValid), .colAddr(colAddr),
  .beatIdx(beatIdx), .colLast(colLast), .colIsRead(colIsRead),
  .rdDue(rdDue), .casCycles(casCycles), .casHalf(casHalf),
  .dllResetReq(dllResetReq), .modeErr(modeErr)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  localparam int COL_W  = 10;
  localparam int BA_W   = 2;
  localparam int ADDR_W = 13;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              mrsValid = 1'b0;
  logic [BA_W-1:0]   mrsBank = '0;
  logic [ADDR_W-1:0] mrsAddr = '0;
  logic              cmdValid = 1'b0;
  logic              cmdIsRead = 1'b0;
  logic [COL_W-1:0]  cmdCol = '0;
  logic              truncate = 1'b0;
  logic              colValid, colLast, colIsRead, rdDue, casHalf, dllResetReq, modeErr;
  logic [COL_W-1:0]  colAddr;
  logic [2:0]        beatIdx;
  logic [1:0]        casCycles;

  burst_col_seq #(.COL_W(COL_W), .BA_W(BA_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .mrsValid(mrsValid), .mrsBank(mrsBank),
    .mrsAddr(mrsAddr), .cmdValid(cmdValid), .cmdIsRead(cmdIsRead),
    .cmdCol(cmdCol), .truncate(truncate), .colValid(colValid),
    .colAddr(colAddr), .beatIdx(beatIdx), .colLast(colLast),
    .colIsRead(colIsRead), .rdDue(rdDue), .casCycles(casCycles),
    .casHalf(casHalf), .dllResetReq(dllResetReq), .modeErr(modeErr)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [COL_W-1:0] addr;
    logic [2:0]       idx;
    logic             last;
    logic             rd;
  } beat_t;

  beat_t sbQ[$];
  int    dueQ[$];
  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  bit    finished = 0;

  int mLen = 4;
  bit mIlv = 0;
  bit mHalf = 0;
  bit mErr = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (colValid) begin
        if (sbQ.size() == 0) begin
          check(1'b0, "R5 unexpected beat", int'(colAddr), 0);
        end else begin
          beat_t e;
          e = sbQ.pop_front();
          check(colAddr == e.addr, "R3/R4 colAddr", int'(colAddr), int'(e.addr));
          check(beatIdx == e.idx, "R5 beatIdx", int'(beatIdx), int'(e.idx));
          check(colLast == e.last, "R2/R5 colLast", int'(colLast), int'(e.last));
          check(colIsRead == e.rd, "R6 colIsRead", int'(colIsRead), int'(e.rd));
        end
      end
      begin
        bit expDue;
        expDue = (dueQ.size() > 0) && (dueQ[0] == cyc);
        if (expDue) void'(dueQ.pop_front());
        if (expDue || rdDue) check(rdDue == expDue, "R7 rdDue", int'(rdDue), int'(expDue));
      end
    end
  end

  task automatic pushBeats(input logic [COL_W-1:0] col, input bit rd);
    int mask;
    mask = mLen - 1;
    for (int k = 0; k < mLen; k++) begin
      beat_t b;
      int off;
      off = mIlv ? ((int'(col) & mask) ^ k) : (((int'(col) & mask) + k) & mask);
      b.addr = COL_W'((int'(col) & ~mask) | off);
      b.idx  = 3'(k);
      b.last = (k == mLen - 1);
      b.rd   = rd;
      sbQ.push_back(b);
    end
    if (rd) dueQ.push_back(cyc + 3);
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (colValid || sbQ.size() != 0);
  endtask

  task automatic burst(input logic [COL_W-1:0] col, input bit rd);
    waitIdle();
    #1;
    pushBeats(col, rd);
    cmdCol = col; cmdIsRead = rd; cmdValid = 1'b1;
    @(negedge clk); #1;
    cmdValid = 1'b0;
  endtask

  task automatic mrs(input logic [BA_W-1:0] bank, input logic [ADDR_W-1:0] addr);
    bit expDll;
    waitIdle();
    #1;
    mrsBank = bank; mrsAddr = addr; mrsValid = 1'b1;
    expDll = 0;
    if (bank == 0) begin
      case (addr[2:0])
        3'b001: mLen = 2;
        3'b010: mLen = 4;
        3'b011: mLen = 8;
        default: mErr = 1;
      endcase
      mIlv = addr[3];
      case (addr[6:4])
        3'b010: mHalf = 0;
        3'b110: mHalf = 1;
        default: mErr = 1;
      endcase
      if (addr[12:7] == 6'd2) expDll = 1;
      else if (addr[12:7] != 6'd0) mErr = 1;
    end
    @(negedge clk);
    check(dllResetReq == expDll, "R10/R8 dllResetReq", int'(dllResetReq), int'(expDll));
    check(casHalf == mHalf, "R7/R8/R9 casHalf", int'(casHalf), int'(mHalf));
    check(casCycles == 2'd2, "R7 casCycles", int'(casCycles), 2);
    check(modeErr == mErr, "R9/R8 modeErr", int'(modeErr), int'(mErr));
    #1 mrsValid = 1'b0;
    @(negedge clk);
    check(dllResetReq == 1'b0, "R10 dll pulse width", int'(dllResetReq), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(colValid == 0, "R1 colValid", int'(colValid), 0);
    check(modeErr == 0, "R1 modeErr", int'(modeErr), 0);
    check(rdDue == 0 && dllResetReq == 0, "R1 rdDue/dll", int'({rdDue, dllResetReq}), 0);
    check(casCycles == 2 && casHalf == 0, "R1 latency", int'({casCycles, casHalf}), 4);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(colValid == 0 && colLast == 0, "R1 after release", int'({colValid, colLast}), 0);

    // R1/R3/R4: default length 4, sequential, wrap
    burst(10'h00D, 0);
    // R2: length 2, sequential
    mrs(0, 13'h021);
    burst(10'h013, 1);
    // R2/R3: length 8, interleaved, read and write (R6)
    mrs(0, 13'h02B);
    burst(10'h1FD, 1);
    burst(10'h03F, 0);
    // R7: half-cycle latency, length 8 sequential
    mrs(0, 13'h063);
    burst(10'h02E, 1);
    // R10: DLL reset with length 4 interleaved, latency 2
    mrs(0, 13'h12A);
    burst(10'h01E, 0);
    // R8: non-zero bank is ignored
    mrs(1, 13'h061);
    mrs(2, 13'h1FF);
    burst(10'h007, 1);
    // R9: reserved length code keeps length 4, order becomes sequential
    mrs(0, 13'h064);
    burst(10'h00B, 0);
    // R9: reserved latency code keeps half flag, length 8 applies
    mrs(0, 13'h033);
    burst(10'h0F6, 1);
    // R9: reserved operating mode, length 2 and latency 2 still apply
    mrs(0, 13'h0A1);
    burst(10'h155, 0);

    // R11: held command waits for the last beat, then follows gaplessly
    mrs(0, 13'h023);
    burst(10'h015, 1);
    #0;
    pushBeats(10'h040, 0);
    cmdCol = 10'h040; cmdIsRead = 0; cmdValid = 1'b1;
    do @(negedge clk); while (!colLast);
    @(negedge clk); #1;
    cmdValid = 1'b0;

    // R11: truncation abandons the running burst
    burst(10'h030, 1);
    @(negedge clk); #1;
    sbQ.delete();
    pushBeats(10'h0A2, 1);
    cmdCol = 10'h0A2; cmdIsRead = 1; truncate = 1'b1; cmdValid = 1'b1;
    @(negedge clk); #1;
    cmdValid = 1'b0; truncate = 1'b0;

    waitIdle();
    repeat (4) @(negedge clk);
    check(sbQ.size() == 0 && dueQ.size() == 0, "R5/R7 queues drained",
          sbQ.size() + dueQ.size(), 0);
    check(modeErr == 1, "R9 sticky at end", int'(modeErr), 1);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule